// File: doc/BRIEF.md
# Bus Hold Arbiter

This block hands the external bus to another master when that master asks for it. The request line is registered on every edge of the fast clock. The bus sequencer only acts on processor-phase ticks, which come once every `PH_DIV` fast edges. A local requester starts transfers through a level request that it holds until a one-clock completion pulse. The arbiter runs each transfer as an address phase (strobe low) followed by a data phase that waits for ready.

When the other master asks for the bus, the arbiter first lets the transfer under way run to its end. If the bus narrows that transfer to half width while both halves carry enabled bytes, the arbiter also runs the second half cycle first. Only then does it grant. In the granted state it raises the acknowledge and drops the output enable that floats the address, byte-enable, status and strobe lines. It leaves that state once the request is sampled low. A local request that arrives meanwhile waits and becomes the first cycle after the bus returns.

Top module: `hold_bus_arbiter`

## Requirements
- R1: `hold_i` is registered on every fast-clock edge and `hlda_o` is raised only after that register holds 1. On an idle bus, `hlda_o` rises within `PH_DIV`+1 fast edges of `hold_i` going high.
- R2: Once an address strobe (`ads_n_o` low) has been issued, `hlda_o` stays low until that transfer completes. This holds for any number of phases without `rdy_i`.
- R3: Suppose `narrow_i` is high when `rdy_i` ends a first-half data phase and the byte enables have bits set in both the low half and the high half. Then a second cycle runs before `hlda_o` can rise, and its byte enables keep only the high half. With 4 lanes the active-low byte enables are 4'b0000 on the first cycle and 4'b0011 on the second.
- R4: With `narrow_i` high, a transfer whose enables lie in one half only takes a single cycle.
- R5: `bus_oe_o` is low and `ads_n_o` is high for every cycle in which `hlda_o` is high. `bus_oe_o` falls on the edge where `hlda_o` rises and rises on the edge where it falls.
- R6: After `hold_i` falls, `hlda_o` falls within `PH_DIV`+1 fast edges, and never before the registered request reads 0.
- R7: While the bus is granted, a local request issues no strobe. After `hlda_o` falls, that request's strobe appears exactly `PH_DIV` fast edges later, carrying the request's address.
- R8: `loc_done_o` is a single-clock pulse, given once per local transfer, including a transfer split into two cycles.
- R9: After reset, `hlda_o` and `loc_done_o` are 0, and `bus_oe_o` and `ads_n_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (2x) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Bus request from the other master |
| hlda_o | output | 1 | Bus grant to the other master |
| loc_req_i | input | 1 | Local transfer request, held until done |
| loc_addr_i | input | ADDR_W | Local word address |
| loc_be_i | input | LANES | Local byte enables, active high |
| loc_wr_i | input | 1 | Local write (1) or read (0) |
| loc_mio_i | input | 1 | Local memory (1) or I/O (0) |
| loc_dc_i | input | 1 | Local data (1) or control (0) |
| loc_done_o | output | 1 | One-clock completion pulse |
| rdy_i | input | 1 | Bus ready, sampled in the data phase |
| narrow_i | input | 1 | Half-width bus indication, sampled with ready |
| addr_o | output | ADDR_W | Bus address |
| be_n_o | output | LANES | Bus byte enables, active low |
| wr_o | output | 1 | Bus write/read status |
| mio_o | output | 1 | Bus memory/I-O status |
| dc_o | output | 1 | Bus data/control status |
| ads_n_o | output | 1 | Address strobe, active low |
| bus_oe_o | output | 1 | Output enable for the floated lines |

## Verification
The bench builds the block with a 16-bit address, 4 byte lanes and `PH_DIV` = 2. Two lanes per half make the split visible as a distinct byte-enable pattern, 4'b0000 and then 4'b0011. With two edges per phase, the bench can count exact latencies at the fast clock, both for entering and leaving the grant and for the strobe that follows it. A short address keeps the address check cheap without changing any sequencing.

// File: rtl/hba_pkg.sv
package hba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } bstate_e;
endpackage

// File: rtl/hba_phase.sv
module hba_phase #(
    parameter int PH_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic tick_o,
    output logic hold_s_o
);
    localparam int CW = (PH_DIV > 2) ? $clog2(PH_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PH_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hold_s;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d        = ph_q;
        ph_d.hold_s = hold_i;
        if (ph_q.cnt == LAST) ph_d.cnt = '0;
        else                  ph_d.cnt = ph_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign tick_o   = (ph_q.cnt == LAST);
    assign hold_s_o = ph_q.hold_s;

    a_r1_sampled_each_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hold_s_o == $past(hold_i)));
endmodule

// File: rtl/hba_seq.sv
module hba_seq
    import hba_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_s_i,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  be_i,
    input  logic              wr_i,
    input  logic              mio_i,
    input  logic              dc_i,
    input  logic              rdy_i,
    input  logic              narrow_i,
    output bstate_e           st_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [LANES-1:0]  cur_be_o,
    output logic              cur_wr_o,
    output logic              cur_mio_o,
    output logic              cur_dc_o,
    output logic              done_o
);
    localparam int HALF = LANES / 2;
    localparam logic [LANES-1:0] HI_MASK = {{(LANES - HALF){1'b1}}, {HALF{1'b0}}};

    typedef struct packed {
        bstate_e           st;
        logic              half2;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic              wr;
        logic              mio;
        logic              dc;
    } seq_t;

    seq_t s_d, s_q;
    logic lo_any, hi_any, split_now;

    assign lo_any    = |s_q.be[HALF-1:0];
    assign hi_any    = |s_q.be[LANES-1:HALF];
    assign split_now = narrow_i && !s_q.half2 && lo_any && hi_any;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (tick_i) begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (hold_s_i) begin
                        s_d.st = ST_HOLD;
                    end else if (req_i) begin
                        s_d.st    = ST_ADDR;
                        s_d.half2 = 1'b0;
                        s_d.addr  = addr_i;
                        s_d.be    = be_i;
                        s_d.wr    = wr_i;
                        s_d.mio   = mio_i;
                        s_d.dc    = dc_i;
                    end
                end
                ST_ADDR: s_d.st = ST_DATA;
                ST_DATA: begin
                    if (rdy_i) begin
                        if (split_now) begin
                            s_d.st    = ST_ADDR;
                            s_d.half2 = 1'b1;
                            s_d.be    = s_q.be & HI_MASK;
                        end else begin
                            s_d.done  = 1'b1;
                            s_d.half2 = 1'b0;
                            s_d.st    = hold_s_i ? ST_HOLD : ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!hold_s_i) s_d.st = ST_IDLE;
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_o       = s_q.st;
    assign cur_addr_o = s_q.addr;
    assign cur_be_o   = s_q.be;
    assign cur_wr_o   = s_q.wr;
    assign cur_mio_o  = s_q.mio;
    assign cur_dc_o   = s_q.dc;
    assign done_o     = s_q.done;

    a_r1_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HOLD && $past(s_q.st) != ST_HOLD) |-> $past(hold_s_i));

    a_r2_no_grant_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ADDR) |=> (s_q.st != ST_HOLD));

    a_r3_split_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HOLD && $past(s_q.st) == ST_DATA) |->
            $past(!(narrow_i && !s_q.half2 && lo_any && hi_any)));

    a_r6_release_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_HOLD && $past(s_q.st) == ST_HOLD) |-> !$past(hold_s_i));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
endmodule

// File: rtl/hba_drive.sv
module hba_drive
    import hba_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LANES  = 4
) (
    input  bstate_e           st_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [LANES-1:0]  cur_be_i,
    input  logic              cur_wr_i,
    input  logic              cur_mio_i,
    input  logic              cur_dc_i,
    output logic              hlda_o,
    output logic              oe_o,
    output logic              ads_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  be_n_o,
    output logic              wr_o,
    output logic              mio_o,
    output logic              dc_o
);
    always_comb begin
        hlda_o  = (st_i == ST_HOLD);
        oe_o    = (st_i != ST_HOLD);
        ads_n_o = (st_i != ST_ADDR);
        addr_o  = cur_addr_i;
        be_n_o  = ~cur_be_i;
        wr_o    = cur_wr_i;
        mio_o   = cur_mio_i;
        dc_o    = cur_dc_i;
    end
endmodule

// File: rtl/hold_bus_arbiter.sv
module hold_bus_arbiter
    import hba_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LANES  = 4,
    parameter int PH_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    output logic              hlda_o,
    input  logic              loc_req_i,
    input  logic [ADDR_W-1:0] loc_addr_i,
    input  logic [LANES-1:0]  loc_be_i,
    input  logic              loc_wr_i,
    input  logic              loc_mio_i,
    input  logic              loc_dc_i,
    output logic              loc_done_o,
    input  logic              rdy_i,
    input  logic              narrow_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  be_n_o,
    output logic              wr_o,
    output logic              mio_o,
    output logic              dc_o,
    output logic              ads_n_o,
    output logic              bus_oe_o
);
    logic              tick, hold_s;
    bstate_e           st;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_be;
    logic              cur_wr, cur_mio, cur_dc;

    hba_phase #(.PH_DIV(PH_DIV)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (hold_i),
        .tick_o   (tick),
        .hold_s_o (hold_s)
    );

    hba_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .hold_s_i   (hold_s),
        .req_i      (loc_req_i),
        .addr_i     (loc_addr_i),
        .be_i       (loc_be_i),
        .wr_i       (loc_wr_i),
        .mio_i      (loc_mio_i),
        .dc_i       (loc_dc_i),
        .rdy_i      (rdy_i),
        .narrow_i   (narrow_i),
        .st_o       (st),
        .cur_addr_o (cur_addr),
        .cur_be_o   (cur_be),
        .cur_wr_o   (cur_wr),
        .cur_mio_o  (cur_mio),
        .cur_dc_o   (cur_dc),
        .done_o     (loc_done_o)
    );

    hba_drive #(.ADDR_W(ADDR_W), .LANES(LANES)) u_drive (
        .st_i       (st),
        .cur_addr_i (cur_addr),
        .cur_be_i   (cur_be),
        .cur_wr_i   (cur_wr),
        .cur_mio_i  (cur_mio),
        .cur_dc_i   (cur_dc),
        .hlda_o     (hlda_o),
        .oe_o       (bus_oe_o),
        .ads_n_o    (ads_n_o),
        .addr_o     (addr_o),
        .be_n_o     (be_n_o),
        .wr_o       (wr_o),
        .mio_o      (mio_o),
        .dc_o       (dc_o)
    );

    a_r5_no_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
        hlda_o |-> (ads_n_o && !bus_oe_o));

    a_r7_no_start_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda_o) |-> ads_n_o);

    a_r9_reset_values: assert property (@(posedge clk)
        !$past(rst_n) |-> (!hlda_o && bus_oe_o && ads_n_o && !loc_done_o));
endmodule

// File: tb/sim_hold_bus_arbiter.sv
module sim_hold_bus_arbiter;
    localparam int AW = 16;
    localparam int LN = 4;
    localparam int PD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold_i = 1'b0;
    logic          hlda_o;
    logic          loc_req_i = 1'b0;
    logic [AW-1:0] loc_addr_i = '0;
    logic [LN-1:0] loc_be_i = '0;
    logic          loc_wr_i = 1'b0, loc_mio_i = 1'b1, loc_dc_i = 1'b1;
    logic          loc_done_o;
    logic          rdy_i = 1'b0, narrow_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic [LN-1:0] be_n_o;
    logic          wr_o, mio_o, dc_o, ads_n_o, bus_oe_o;

    int checks = 0;
    int errors = 0;

    int ads_cnt = 0, done_cnt = 0, viol_busy = 0, viol_done = 0, viol_oe = 0;
    logic ads_prev = 1'b1, done_prev = 1'b0, busy = 1'b0;
    logic [LN-1:0] last_be_n = '0;

    always #2 clk = ~clk;

    hold_bus_arbiter #(.ADDR_W(AW), .LANES(LN), .PH_DIV(PD)) u0 (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .hlda_o(hlda_o),
        .loc_req_i(loc_req_i), .loc_addr_i(loc_addr_i), .loc_be_i(loc_be_i),
        .loc_wr_i(loc_wr_i), .loc_mio_i(loc_mio_i), .loc_dc_i(loc_dc_i),
        .loc_done_o(loc_done_o), .rdy_i(rdy_i), .narrow_i(narrow_i),
        .addr_o(addr_o), .be_n_o(be_n_o), .wr_o(wr_o), .mio_o(mio_o),
        .dc_o(dc_o), .ads_n_o(ads_n_o), .bus_oe_o(bus_oe_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (loc_done_o) busy = 1'b0;
            else if (ads_prev && !ads_n_o) busy = 1'b1;
            if (ads_prev && !ads_n_o) begin
                ads_cnt++;
                last_be_n = be_n_o;
            end
            if (loc_done_o) done_cnt++;
            if (loc_done_o && done_prev) viol_done++;
            if (hlda_o && busy) viol_busy++;
            if (hlda_o && (bus_oe_o || !ads_n_o)) viol_oe++;
            if (!hlda_o && !bus_oe_o) viol_oe++;
        end
        ads_prev  = ads_n_o;
        done_prev = loc_done_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_hlda(input logic val, output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n++;
            if (hlda_o == val) break;
        end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            n++;
            if (loc_done_o) break;
        end
        loc_req_i = 1'b0;
    endtask

    task automatic wait_ads(output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n++;
            if (!ads_n_o) break;
        end
    endtask

    task automatic start_req(input logic [AW-1:0] a, input logic [LN-1:0] be);
        loc_addr_i = a;
        loc_be_i   = be;
        loc_req_i  = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!hlda_o, "R9 hlda", int'(hlda_o), 0);
        check(bus_oe_o, "R9 oe", int'(bus_oe_o), 1);
        check(ads_n_o, "R9 ads_n", int'(ads_n_o), 1);
        check(!loc_done_o, "R9 done", int'(loc_done_o), 0);
    endtask

    task automatic t_idle_grant;
        int n;
        @(negedge clk);
        hold_i = 1'b1;
        wait_hlda(1'b1, n);
        check(hlda_o && n >= 2 && n <= PD + 1, "R1 grant latency", n, PD + 1);
        check(!bus_oe_o, "R5 oe off with grant", int'(bus_oe_o), 0);
        repeat (6) @(negedge clk);
        check(hlda_o && !bus_oe_o && ads_n_o, "R5 granted state held", int'(bus_oe_o), 0);
        hold_i = 1'b0;
        wait_hlda(1'b0, n);
        check(!hlda_o && n >= 2 && n <= PD + 1, "R6 release latency", n, PD + 1);
        check(bus_oe_o, "R5 oe back with release", int'(bus_oe_o), 1);
    endtask

    task automatic t_mid_cycle;
        int n, a0, d0, bad;
        a0 = ads_cnt; d0 = done_cnt; bad = 0;
        rdy_i = 1'b0; narrow_i = 1'b0;
        @(negedge clk);
        start_req(16'h1234, 4'b1111);
        wait_ads(n);
        hold_i = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (hlda_o) bad++;
        end
        check(bad == 0, "R2 no grant while waiting ready", bad, 0);
        rdy_i = 1'b1;
        wait_done(n);
        wait_hlda(1'b1, n);
        check(hlda_o, "R2 grant after completion", int'(hlda_o), 1);
        check(ads_cnt - a0 == 1, "R2 single cycle", ads_cnt - a0, 1);
        check(done_cnt - d0 == 1, "R8 one done", done_cnt - d0, 1);
        hold_i = 1'b0;
        wait_hlda(1'b0, n);
        rdy_i = 1'b0;
    endtask

    task automatic t_split;
        int n, a0, d0;
        logic [LN-1:0] first_be;
        a0 = ads_cnt; d0 = done_cnt;
        rdy_i = 1'b1; narrow_i = 1'b1;
        @(negedge clk);
        start_req(16'h0420, 4'b1111);
        wait_ads(n);
        first_be = be_n_o;
        hold_i = 1'b1;
        wait_done(n);
        wait_hlda(1'b1, n);
        check(first_be == 4'b0000, "R3 first half enables", int'(first_be), 0);
        check(ads_cnt - a0 == 2, "R3 two cycles before grant", ads_cnt - a0, 2);
        check(last_be_n == 4'b0011, "R3 second half enables", int'(last_be_n), 3);
        check(done_cnt - d0 == 1, "R8 one done for split", done_cnt - d0, 1);
        hold_i = 1'b0;
        wait_hlda(1'b0, n);
    endtask

    task automatic t_single_narrow;
        int n, a0, d0;
        a0 = ads_cnt; d0 = done_cnt;
        rdy_i = 1'b1; narrow_i = 1'b1;
        @(negedge clk);
        start_req(16'h0044, 4'b0011);
        wait_done(n);
        repeat (6) @(negedge clk);
        check(ads_cnt - a0 == 1, "R4 one cycle low half", ads_cnt - a0, 1);
        check(last_be_n == 4'b1100, "R4 enables", int'(last_be_n), 12);
        check(done_cnt - d0 == 1, "R8 done narrow", done_cnt - d0, 1);
        a0 = ads_cnt;
        start_req(16'h0048, 4'b1100);
        wait_done(n);
        repeat (6) @(negedge clk);
        check(ads_cnt - a0 == 1, "R4 one cycle high half", ads_cnt - a0, 1);
        narrow_i = 1'b0;
    endtask

    task automatic t_queue;
        int n, a0, bad;
        a0 = ads_cnt; bad = 0;
        rdy_i = 1'b1;
        @(negedge clk);
        hold_i = 1'b1;
        wait_hlda(1'b1, n);
        start_req(16'hBEEF, 4'b0001);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!ads_n_o || bus_oe_o) bad++;
        end
        check(bad == 0 && ads_cnt == a0, "R7 no strobe while granted", bad, 0);
        hold_i = 1'b0;
        wait_hlda(1'b0, n);
        wait_ads(n);
        check(n == PD, "R7 strobe delay after release", n, PD);
        check(addr_o == 16'hBEEF, "R7 queued address", int'(addr_o), 16'hBEEF);
        check(bus_oe_o, "R5 driven again", int'(bus_oe_o), 1);
        wait_done(n);
        check(loc_done_o, "R8 queued transfer done", int'(loc_done_o), 1);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_grant();
        t_mid_cycle();
        t_split();
        t_single_narrow();
        t_queue();
        repeat (8) @(negedge clk);
        check(viol_busy == 0, "R2 monitor grant during transfer", viol_busy, 0);
        check(viol_done == 0, "R8 monitor done width", viol_done, 0);
        check(viol_oe == 0, "R5 monitor enable vs grant", viol_oe, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule